// File: doc/BRIEF.md
# Polyphase 1-D Pixel Resampler

This block rescales one line of 8-bit samples, such as one colour component of a video line, to a programmed number of output samples. Each output has a 16.16 fixed-point position in the input line. The integer part of that position picks a window of four neighbouring input samples. The top five fractional bits pick one of 32 filter phases. Each phase has four signed taps, and the weighted sum of the window is normalised back to 8 bits.

Software programs the block through a small register write port. It writes 32 staged phase words, the input-per-output step, a starting fraction and the output count per line. A commit write then makes the staged phase words live. Samples arrive and leave on valid/ready streams. A start pulse opens each line, and a marker on the final input sample closes it.

Top module: `polyphase_resampler`

## Requirements
- R1: After reset `out_valid` and `in_ready` are low, the step is 1.0 (0x0001_0000), the output count is 0, and all 32 live phase words hold 0x0000_4000. With those words every output equals the input sample at its integer position.
- R2: A write with `cfg_addr` 0..31 stages the phase word for that phase. Address 32 sets the 32-bit step. Address 33 sets the starting fraction from `cfg_wdata[15:0]`. Address 34 sets the output count from `cfg_wdata[15:0]`. A write to address 35 with `cfg_wdata[0]`=1 is a commit.
- R3: Byte j of a phase word (bits 8j+7..8j) is a two's-complement tap. It weights the input sample at index c-1+j, where c is the integer part of the output position.
- R4: Each output is (sum of tap times sample + 32) shifted arithmetically right by 6, then limited to the range 0..255.
- R5: Output k of a line has position P = start_fraction + k*step, with 16 integer and 16 fractional bits. Its phase is bits [15:11] of P.
- R6: Staged phase words have no effect on any output until a commit. A commit copies all 32 staged words into the live table in one clock. A write to address 35 with bit 0 clear does not commit.
- R7: A window index below 0 uses the first sample of the line. An index past the end of the line uses the sample that carried `in_last`.
- R8: After a start pulse the block sends exactly the programmed output count and raises `out_last` on the final one. It then accepts and discards any input left in the line up to `in_last`, and waits with `in_ready` low. A start pulse while a line is in progress is ignored.
- R9: A sample moves only in a cycle where valid and ready are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R10: A commit made while an output waits in the output register leaves that output as it is. Every later output of the line uses the committed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| line_start | input | 1 | Pulse that opens a line |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts an input sample |
| in_data | input | 8 | Input sample |
| in_last | input | 1 | Marks the final input sample of the line |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 8 | Output sample |
| out_last | output | 1 | Marks the final output of the line |

## Verification
A commit can arrive in the same cycle that a filtered result sits in the output register, waiting for the next one to be computed. The bench provokes this by holding `out_ready` low until the first output of a line appears. It then commits a staged table and also pulses `line_start` mid-line. The bench expects output 0 to carry the old table's value, every later output to carry the new table's value, and the line length to be unchanged by the stray start pulse.

// File: rtl/rs_pkg.sv
package rs_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PIX_W   = 8;
  localparam int unsigned TAP_W   = 8;
  localparam int unsigned NTAPS   = 4;
  localparam int unsigned COEF_W  = NTAPS * TAP_W;
  localparam int unsigned NORM_SH = 6;
  localparam int          ROUND_ADD = 1 << (NORM_SH - 1);
  localparam int          PIX_MAX   = (1 << PIX_W) - 1;

  localparam int unsigned CFG_AW = 6;
  localparam int unsigned CFG_DW = 32;
  localparam logic [CFG_AW-1:0] A_STEP   = 6'd32;
  localparam logic [CFG_AW-1:0] A_INIT   = 6'd33;
  localparam logic [CFG_AW-1:0] A_OSIZE  = 6'd34;
  localparam logic [CFG_AW-1:0] A_COMMIT = 6'd35;

  // identity word: only the second tap (centre sample) is active, weight 64
  localparam logic [COEF_W-1:0] COEF_IDENT = 32'h0000_4000;

  typedef enum logic [1:0] {LN_IDLE, LN_RUN, LN_DRAIN} line_st_e;

  // weighted sum of the window, rounded, normalised and limited to pixel range
  function automatic logic [PIX_W-1:0] rs_fir(input logic [COEF_W-1:0]      coef,
                                              input logic [NTAPS*PIX_W-1:0] win);
    int sum;
    int tap;
    int pix;
    sum = 0;
    for (int j = 0; j < NTAPS; j++) begin
      tap = int'($signed(coef[j*TAP_W +: TAP_W]));
      pix = int'({1'b0, win[j*PIX_W +: PIX_W]});
      sum = sum + tap * pix;
    end
    sum = (sum + ROUND_ADD) >>> NORM_SH;
    if (sum < 0) return '0;
    if (sum > PIX_MAX) return '1;
    return PIX_W'(sum);
  endfunction
endpackage

// File: rtl/rs_coef_bank.sv
module rs_coef_bank #(
  parameter int unsigned PHASES = 32,
  parameter int unsigned COEF_W = 32,
  parameter logic [COEF_W-1:0] INIT_COEF = '0,
  localparam int unsigned IDX_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              commit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COEF_W-1:0] rd_coef
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [COEF_W-1:0] stage_q  [PHASES];
  logic [COEF_W-1:0] active_q [PHASES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PHASES; p++) begin
        stage_q[p]  <= INIT_COEF;
        active_q[p] <= INIT_COEF;
      end
    end else begin
      if (wr_en) stage_q[wr_idx] <= wr_data;
      if (commit) begin
        for (int p = 0; p < PHASES; p++) active_q[p] <= stage_q[p];
      end
    end
  end

  assign rd_coef = active_q[rd_idx];
endmodule

// File: rtl/rs_window.sv
module rs_window #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned NTAPS = 4,
  parameter int unsigned POS_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   load,
  input  logic                   dup,
  input  logic [PIX_W-1:0]       din,
  output logic [NTAPS*PIX_W-1:0] win,
  output logic [POS_W-1:0]       pos
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WIN_W = NTAPS * PIX_W;

  logic [WIN_W-1:0] win_q;
  logic [POS_W-1:0] pos_q;
  logic [PIX_W-1:0] new_px;

  // lowest byte holds the oldest sample, top byte the newest
  assign new_px = load ? din : win_q[WIN_W-1 -: PIX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      pos_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
    end else if (load || dup) begin
      pos_q <= pos_q + POS_W'(1);
      if (load && pos_q == '0) win_q <= {NTAPS{din}};
      else                     win_q <= {new_px, win_q[WIN_W-1:PIX_W]};
    end
  end

  assign win = win_q;
  assign pos = pos_q;
endmodule

// File: rtl/polyphase_resampler.sv
module polyphase_resampler
  import rs_pkg::*;
#(
  parameter int unsigned PHASES = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              line_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data,
  output logic              out_last
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned ACC_W = SIZE_W + FRAC_W;
  localparam int unsigned IDX_W = $clog2(PHASES);
  localparam int unsigned POS_W = SIZE_W + 2;
  localparam int unsigned AHEAD = NTAPS - 1;

  // ---------------- configuration registers ----------------
  logic [ACC_W-1:0]  step_q;
  logic [FRAC_W-1:0] init_q;
  logic [SIZE_W-1:0] osize_q;
  logic              coef_we, commit;

  assign coef_we = cfg_we && !cfg_addr[CFG_AW-1];
  assign commit  = cfg_we && (cfg_addr == A_COMMIT) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= ACC_W'(1) << FRAC_W;
      init_q  <= '0;
      osize_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_STEP)  step_q  <= cfg_wdata[ACC_W-1:0];
      if (cfg_addr == A_INIT)  init_q  <= cfg_wdata[FRAC_W-1:0];
      if (cfg_addr == A_OSIZE) osize_q <= cfg_wdata[SIZE_W-1:0];
    end
  end

  // ---------------- line sequencing state ----------------
  line_st_e          st_q;
  logic [ACC_W-1:0]  acc_q;
  logic [SIZE_W-1:0] out_cnt_q;
  logic              ended_q;

  logic [SIZE_W-1:0]      centre;
  logic [IDX_W-1:0]       phase;
  logic [POS_W-1:0]       need, pos;
  logic                   need_more;
  logic                   line_idle, line_run, line_drain, start_ok;
  logic                   in_fire, win_load, win_repeat, emit, final_emit;
  logic [NTAPS*PIX_W-1:0] win;
  logic [COEF_W-1:0]      coef;

  assign centre     = acc_q[ACC_W-1:FRAC_W];
  assign phase      = acc_q[FRAC_W-1 -: IDX_W];
  assign need       = POS_W'(centre) + POS_W'(AHEAD);
  assign need_more  = pos < need;
  assign line_idle  = (st_q == LN_IDLE);
  assign line_run   = (st_q == LN_RUN);
  assign line_drain = (st_q == LN_DRAIN);
  assign start_ok   = line_start && line_idle;

  assign in_ready   = !ended_q && ((line_run && need_more) || line_drain);
  assign in_fire    = in_valid && in_ready;
  assign win_load   = in_fire && line_run;
  assign win_repeat = line_run && ended_q && need_more;
  assign emit       = line_run && !need_more && (!out_valid || out_ready);
  assign final_emit = emit && (out_cnt_q == osize_q - SIZE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= LN_IDLE;
      acc_q     <= '0;
      out_cnt_q <= '0;
      ended_q   <= 1'b0;
    end else begin
      case (st_q)
        LN_IDLE: if (line_start) begin
          acc_q     <= ACC_W'(init_q);
          out_cnt_q <= '0;
          ended_q   <= 1'b0;
          st_q      <= (osize_q == '0) ? LN_DRAIN : LN_RUN;
        end
        LN_RUN: begin
          if (in_fire && in_last) ended_q <= 1'b1;
          if (emit) begin
            acc_q     <= acc_q + step_q;
            out_cnt_q <= out_cnt_q + SIZE_W'(1);
            if (final_emit) st_q <= ended_q ? LN_IDLE : LN_DRAIN;
          end
        end
        LN_DRAIN: if (in_fire && in_last) begin
          ended_q <= 1'b1;
          st_q    <= LN_IDLE;
        end
        default: st_q <= LN_IDLE;
      endcase
    end
  end

  // ---------------- datapath ----------------
  rs_coef_bank #(.PHASES(PHASES), .COEF_W(COEF_W), .INIT_COEF(COEF_IDENT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (coef_we),
    .wr_idx  (cfg_addr[IDX_W-1:0]),
    .wr_data (cfg_wdata[COEF_W-1:0]),
    .commit  (commit),
    .rd_idx  (phase),
    .rd_coef (coef)
  );

  rs_window #(.PIX_W(PIX_W), .NTAPS(NTAPS), .POS_W(POS_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_ok),
    .load  (win_load),
    .dup   (win_repeat),
    .din   (in_data),
    .win   (win),
    .pos   (pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= rs_fir(coef, win);
      out_last  <= final_emit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_data,
  input logic              out_last,
  input logic              emit,
  input logic [SIZE_W-1:0] out_cnt,
  input logic [SIZE_W-1:0] osize,
  input logic              line_idle,
  input logic              line_run
);
  timeunit 1ns;
  timeprecision 1ps;

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> out_cnt < osize);

  a_r8_idle_no_input: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> !in_ready);

  a_r8_last_closes_run: assert property (@(posedge clk) disable iff (!rst_n)
    emit && (out_cnt == osize - SIZE_W'(1)) |=> !line_run);

  a_r8_last_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    emit && (out_cnt == osize - SIZE_W'(1)) |=> out_valid && out_last);
endmodule

bind polyphase_resampler rs_checker #(.SIZE_W(SIZE_W), .PIX_W(rs_pkg::PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .emit      (emit),
  .out_cnt   (out_cnt_q),
  .osize     (osize_q),
  .line_idle (line_idle),
  .line_run  (line_run)
);

// File: tb/polyphase_resampler_tb.sv
module polyphase_resampler_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        line_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;

  always #2.5 clk = ~clk;   // 200 MHz

  polyphase_resampler dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .line_start(line_start), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] tbl_act   [32];
  logic [31:0] tbl_stage [32];
  int line_px [64];
  int exp_a [64];
  int exp_b [64];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  // independent model of one output sample (R3, R4, R5, R7)
  function automatic int model_px(input int k, input int len, input int unsigned init,
                                  input int unsigned step, input logic [31:0] t [32]);
    longint pos;
    int c, ph, sum, tap, idx;
    pos = longint'(init) + longint'(k) * longint'(step);
    c   = int'(pos >> 16);
    ph  = int'((pos >> 11) & 31);
    sum = 0;
    for (int j = 0; j < 4; j++) begin
      idx = c - 1 + j;
      if (idx < 0) idx = 0;
      if (idx > len - 1) idx = len - 1;
      tap = int'(t[ph][8*j +: 8]);
      if (tap > 127) tap = tap - 256;
      sum = sum + tap * line_px[idx];
    end
    sum = sum + 32;
    sum = (sum >= 0) ? sum / 64 : -((-sum + 63) / 64);
    if (sum < 0) sum = 0;
    if (sum > 255) sum = 255;
    return sum;
  endfunction

  task automatic cfg_wr(input int a, input int unsigned d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 32) tbl_stage[a] = d;
    if (a == 35 && d[0]) for (int p = 0; p < 32; p++) tbl_act[p] = tbl_stage[p];
  endtask

  // mode 0: taps summing to 64; mode 1: arbitrary signed bytes
  task automatic stage_table(input int mode);
    int b0, b1, b2, b3;
    for (int p = 0; p < 32; p++) begin
      if (mode == 0) begin
        b0 = int'($urandom_range(0, 31)) - 16;
        b2 = int'($urandom_range(0, 40));
        b3 = -int'($urandom_range(0, 10));
        b1 = 64 - b0 - b2 - b3;
      end else begin
        b0 = int'($urandom_range(0, 255)); b1 = int'($urandom_range(0, 255));
        b2 = int'($urandom_range(0, 255)); b3 = int'($urandom_range(0, 255));
      end
      cfg_wr(p, {8'(b3), 8'(b2), 8'(b1), 8'(b0)});
    end
  endtask

  task automatic run_line(input string tag, input int len, input int n,
                          input int unsigned init, input bit mid);
    int unsigned step;
    step = (int'(len) << 16) / n;
    for (int i = 0; i < len; i++) line_px[i] = int'($urandom_range(0, 255));
    cfg_wr(32, step);
    cfg_wr(33, init);
    cfg_wr(34, n);
    for (int k = 0; k < n; k++) begin
      exp_a[k] = model_px(k, len, init, step, tbl_act);
      exp_b[k] = model_px(k, len, init, step, tbl_stage);
    end
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
    fork
      begin : drv
        int idx = 0;
        while (idx < len) begin
          @(negedge clk);
          in_valid = ($urandom_range(0, 3) != 0);
          in_data  = 8'(line_px[idx]);
          in_last  = (idx == len - 1);
          #2;
          if (in_valid && in_ready) idx++;
        end
        @(negedge clk); in_valid = 0; in_last = 0;
      end
      begin : col
        int k = 0;
        int e;
        if (mid) begin
          out_ready = 0;
          while (!out_valid) @(negedge clk);
          repeat (3) @(negedge clk);
          line_start = 1;                 // R8: ignored mid-line
          @(negedge clk); line_start = 0;
          cfg_wr(35, 1);                  // R10: commit while output 0 is held
        end
        while (k < n) begin
          @(negedge clk);
          out_ready = ($urandom_range(0, 2) != 0);
          #2;
          if (out_valid && out_ready) begin
            e = mid ? ((k == 0) ? exp_a[k] : exp_b[k]) : exp_a[k];
            chk({tag, " sample"}, int'(out_data), e);
            chk("R8 out_last", int'(out_last), int'(k == n - 1));
            k++;
          end
        end
        @(negedge clk); out_ready = 0;
      end
    join
    @(negedge clk);
    chk("R8 idle after line in_ready", int'(in_ready), 0);
    chk("R8 idle after line out_valid", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 32; p++) begin
      tbl_act[p] = 32'h0000_4000;
      tbl_stage[p] = 32'h0000_4000;
    end
    repeat (4) @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 0);
    chk("R1 reset out_valid", int'(out_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle in_ready", int'(in_ready), 0);

    run_line("R1 identity table", 8, 8, 0, 0);
    stage_table(0);
    cfg_wr(35, 1);
    run_line("R5 upscale", 5, 17, 0, 0);
    run_line("R3 R7 downscale with drain", 40, 7, 16'h4000, 0);
    run_line("R7 single sample line", 1, 5, 16'hF000, 0);
    stage_table(1);
    cfg_wr(35, 0);                         // R6: bit 0 clear, no commit
    run_line("R6 staged not live", 12, 9, 0, 0);
    run_line("R10 commit while held", 10, 14, 16'h0800, 1);
    run_line("R4 clamp wild taps", 20, 31, 16'h2000, 0);

    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(0, 2) == 0) stage_table(int'($urandom_range(0, 1)));
      cfg_wr(35, $urandom_range(0, 3));    // R6: commit only when bit 0 set
      run_line("R2 R5 random line", int'($urandom_range(1, 48)), int'($urandom_range(1, 48)),
               ($urandom_range(0, 1) != 0) ? 16'($urandom) : 0, 0);
    end
    report();
  end
endmodule